// File: doc/BRIEF.md
# I2C Bus START/STOP Condition Tracker

This block watches the two wires of an I2C bus, the data line and the clock line, and keeps a bus-active state for a slave that runs without a free-running system clock. A START condition (data falling while the clock line is high) sets the state. A STOP condition (data rising while the clock line is high) clears it. The bus-active output then enables a downstream slave state machine that is clocked on the falling edge of the bus clock. Before any START, that machine sees no enable, so clock edges on an idle bus cannot advance it.

Detection uses flip-flops that are clocked by edges of the data line and that look at the level of the clock line. A falling-edge catcher and a rising-edge catcher reset each other with a short self-timed pulse. This gives no standby power beyond the bus activity itself. The tracker also handles bus sequences that are rare but possible. A STOP and a START can share one clock-high period. A START can be followed at once by a STOP with no clock pulse between them. A START can arrive while a transfer is already open (a repeated START). A toggle output flips once for every STOP, so logic in another clock domain can count stops without having to catch a narrow pulse.

Top module: `i2c_cond_tracker`

## Requirements
- R1: When data falls while the clock line is high and `rst` is low, `bus_active` becomes 1.
- R2: When data rises while the clock line is high and `bus_active` is 1, `bus_active` becomes 0, `rep_start` becomes 0 and `stop_toggle` inverts once.
- R3: Data changes while the clock line is low never alter `bus_active`, `rep_start` or `stop_toggle`.
- R4: While `bus_active` is 0, clock toggling, data toggling and a STOP-shaped edge leave all three outputs unchanged.
- R5: A STOP followed by a START inside one clock-high period inverts `stop_toggle` exactly once and leaves `bus_active` at 1 with `rep_start` at 0.
- R6: A START followed directly by a STOP with no clock pulse between them returns `bus_active` to 0 and inverts `stop_toggle` once.
- R7: A START seen while `bus_active` is 1 keeps `bus_active` at 1 and sets `rep_start` to 1. `rep_start` stays 1 until the next STOP or reset, and is 1 only while `bus_active` is 1.
- R8: `rst` at 1 clears `bus_active`, `rep_start` and `stop_toggle` to 0 at once and without any clock, and holds them at 0 for as long as it stays high. Bus conditions that arrive during reset are lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst | input | 1 | Asynchronous reset, active high |
| scl | input | 1 | Bus clock line level |
| sda | input | 1 | Bus data line level |
| bus_active | output | 1 | 1 from a START up to the following STOP |
| rep_start | output | 1 | 1 when the open transfer began with a repeated START |
| stop_toggle | output | 1 | Inverts once per STOP |

## Verification
The hardest situation to reach is the one where two conditions fall inside a single clock-high period. That is a STOP and then a START, or a START and then a STOP. The self-timed cross-reset must finish between the two data edges for both conditions to register. The stimulus holds the clock line high and moves only the data line, with several steps in a row. After each step it compares the outputs with a behavioural model that is updated on every data edge. Repeated START and a reset that arrives mid-transfer are reached by first opening a transfer with data bits, so that the state being cleared is not already zero.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;

    // Observable bus state handed to downstream logic
    typedef struct packed {
        logic active;
        logic rep;
        logic stop_tgl;
    } bus_status_t;

    localparam bus_status_t STATUS_IDLE = '{active: 1'b0, rep: 1'b0, stop_tgl: 1'b0};

    // A condition edge counts only while the clock line is high
    function automatic logic cond_window(input logic scl_level);
        return scl_level;
    endfunction

endpackage

// File: rtl/i2c_start_catch.sv
module i2c_start_catch
    import i2c_cond_pkg::*;
(
    input  logic clr,
    input  logic scl,
    input  logic sda,
    output logic start_q,
    output logic bus_q,
    output logic rep_q
);

    // start_q feeds only the self-timed reset network
    always_ff @(negedge sda or posedge clr) begin
        if (clr)
            start_q <= 1'b0;
        else if (cond_window(scl))
            start_q <= 1'b1;
    end

    // bus_q is an observation copy, kept away from the async network
    always_ff @(negedge sda or posedge clr) begin
        if (clr)
            bus_q <= 1'b0;
        else if (cond_window(scl))
            bus_q <= 1'b1;
    end

    // repeated START: a START edge that finds the bus already open
    always_ff @(negedge sda or posedge clr) begin
        if (clr)
            rep_q <= 1'b0;
        else if (cond_window(scl))
            rep_q <= bus_q;
    end

endmodule

// File: rtl/i2c_stop_catch.sv
module i2c_stop_catch
    import i2c_cond_pkg::*;
(
    input  logic rst,
    input  logic clr,
    input  logic scl,
    input  logic sda,
    output logic stop_q,
    output logic tgl_q
);

    // held clear while no START is open; sets on a STOP edge
    always_ff @(posedge sda or posedge clr) begin
        if (clr)
            stop_q <= 1'b0;
        else if (cond_window(scl))
            stop_q <= 1'b1;
    end

    // every self-timed stop pulse flips the event toggle
    always_ff @(posedge stop_q or posedge rst) begin
        if (rst)
            tgl_q <= 1'b0;
        else
            tgl_q <= ~tgl_q;
    end

endmodule

// File: rtl/i2c_cond_tracker.sv
module i2c_cond_tracker
    import i2c_cond_pkg::*;
(
    input  logic rst,
    input  logic scl,
    input  logic sda,
    output logic bus_active,
    output logic rep_start,
    output logic stop_toggle
);

    logic start_q;
    logic bus_q;
    logic rep_q;
    logic stop_q;
    logic tgl_q;
    logic start_clr;
    logic stop_clr;
    bus_status_t status;

    // cross-reset: a set stop flop clears the start side,
    // a clear start side clears the stop flop again
    assign start_clr = rst | stop_q;
    assign stop_clr  = rst | ~start_q;

    i2c_start_catch u_start (
        .clr     (start_clr),
        .scl     (scl),
        .sda     (sda),
        .start_q (start_q),
        .bus_q   (bus_q),
        .rep_q   (rep_q)
    );

    i2c_stop_catch u_stop (
        .rst    (rst),
        .clr    (stop_clr),
        .scl    (scl),
        .sda    (sda),
        .stop_q (stop_q),
        .tgl_q  (tgl_q)
    );

    always_comb begin
        status          = STATUS_IDLE;
        status.active   = bus_q;
        status.rep      = rep_q;
        status.stop_tgl = tgl_q;
    end

    assign bus_active  = status.active;
    assign rep_start   = status.rep;
    assign stop_toggle = status.stop_tgl;

endmodule

// File: rtl/i2c_cond_tracker_chk.sv
module i2c_cond_tracker_chk (
    input logic rst,
    input logic scl,
    input logic sda,
    input logic bus_active,
    input logic rep_start,
    input logic stop_toggle
);

    logic low_valid;
    logic low_active;
    logic low_rep;
    logic low_tgl;

    // snapshot the state when the clock line falls
    always_ff @(negedge scl or posedge rst) begin
        if (rst) begin
            low_valid  <= 1'b0;
            low_active <= 1'b0;
            low_rep    <= 1'b0;
            low_tgl    <= 1'b0;
        end else begin
            low_valid  <= 1'b1;
            low_active <= bus_active;
            low_rep    <= rep_start;
            low_tgl    <= stop_toggle;
        end
    end

    // R3: the low phase of the clock line leaves the state untouched
    assert_low_active_hold_R3: assert property (@(posedge scl) disable iff (rst)
        low_valid |-> (bus_active == low_active));

    assert_low_toggle_hold_R3: assert property (@(posedge scl) disable iff (rst)
        low_valid |-> (stop_toggle == low_tgl));

    assert_low_rep_hold_R3: assert property (@(posedge scl) disable iff (rst)
        low_valid |-> (rep_start == low_rep));

    // R7: a repeated START flag never appears on an idle bus
    assert_rep_needs_active_R7: assert property (@(negedge scl) disable iff (rst)
        rep_start |-> bus_active);

    // R8: leaving reset finds every output cleared
    always @(negedge rst) begin
        assert_reset_clear_R8: assert (!bus_active && !rep_start && !stop_toggle);
    end

    // sda is part of the bound port set but not checked here
    logic unused_sda;
    assign unused_sda = sda;

endmodule

bind i2c_cond_tracker i2c_cond_tracker_chk u_chk (
    .rst         (rst),
    .scl         (scl),
    .sda         (sda),
    .bus_active  (bus_active),
    .rep_start   (rep_start),
    .stop_toggle (stop_toggle)
);

// File: tb/test_i2c_cond_tracker.sv
`timescale 1ns/1ps
module test_i2c_cond_tracker;

    localparam int STEP = 40;

    logic clk = 1'b0;
    logic rst = 1'b0;
    logic scl = 1'b1;
    logic sda = 1'b1;
    logic bus_active;
    logic rep_start;
    logic stop_toggle;

    int checks   = 0;
    int failures = 0;
    logic done = 1'b0;

    // behavioural expectation
    logic exp_active = 1'b0;
    logic exp_rep    = 1'b0;
    logic exp_tgl    = 1'b0;

    always #5 clk = ~clk;

    i2c_cond_tracker i_i2c_cond_tracker (
        .rst         (rst),
        .scl         (scl),
        .sda         (sda),
        .bus_active  (bus_active),
        .rep_start   (rep_start),
        .stop_toggle (stop_toggle)
    );

    always @(posedge rst) begin
        exp_active = 1'b0;
        exp_rep    = 1'b0;
        exp_tgl    = 1'b0;
    end

    always @(sda) begin
        if (!rst && scl === 1'b1) begin
            if (sda === 1'b0) begin
                exp_rep    = exp_active;
                exp_active = 1'b1;
            end else if (exp_active) begin
                exp_active = 1'b0;
                exp_rep    = 1'b0;
                exp_tgl    = ~exp_tgl;
            end
        end
    end

    // compare with the model on every clock, away from bus edges
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (bus_active !== exp_active || rep_start !== exp_rep || stop_toggle !== exp_tgl) begin
                failures++;
                $display("FAIL model(R1 R2 R7) act=%b%b%b exp=%b%b%b at %0t",
                         bus_active, rep_start, stop_toggle, exp_active, exp_rep, exp_tgl, $time);
            end
        end
    end

    task automatic chk(input string req, input logic [2:0] expv);
        checks++;
        if ({bus_active, rep_start, stop_toggle} !== expv) begin
            failures++;
            $display("FAIL %s act=%b exp=%b at %0t", req,
                     {bus_active, rep_start, stop_toggle}, expv, $time);
        end
    endtask

    task automatic set_scl(input logic v);
        scl = v;
        #STEP;
    endtask

    task automatic set_sda(input logic v);
        sda = v;
        #STEP;
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            set_scl(1'b0);
            set_sda(b[i]);
            set_scl(1'b1);
        end
        set_scl(1'b0);
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #1 rst = 1'b1;
        #(STEP + 2);
        chk("R8 reset state", 3'b000);
        rst = 1'b0;
        #STEP;

        // R4: idle bus activity, including a STOP-shaped edge
        set_scl(1'b0); set_sda(1'b0); set_scl(1'b1); set_sda(1'b1);
        set_scl(1'b0); set_sda(1'b0); set_scl(1'b1); set_scl(1'b0);
        set_sda(1'b1); set_scl(1'b1);
        chk("R4 idle ignored", 3'b000);

        // R1: START
        set_sda(1'b0);
        chk("R1 start", 3'b100);

        // R3: data bits while clock low
        send_byte(8'hA5);
        chk("R3 data bits", 3'b100);

        // R7: repeated START
        set_sda(1'b1); set_scl(1'b1); set_sda(1'b0);
        chk("R7 repeated start", 3'b110);
        send_byte(8'h3C);
        chk("R7 rep held over data", 3'b110);

        // R2: STOP
        set_sda(1'b0); set_scl(1'b1); set_sda(1'b1);
        chk("R2 stop", 3'b001);

        // R5: STOP then START in one clock-high period
        set_sda(1'b0);
        chk("R1 start again", 3'b101);
        set_scl(1'b0); set_scl(1'b1);
        set_sda(1'b1); set_sda(1'b0);
        chk("R5 stop+start", 3'b100);

        // R6: empty frame
        set_sda(1'b1);
        chk("R2 stop before empty frame", 3'b001);
        set_sda(1'b0); set_sda(1'b1);
        chk("R6 empty frame", 3'b000);

        // R8: reset in the middle of a transfer
        set_sda(1'b0);
        set_scl(1'b0); set_scl(1'b1); set_sda(1'b1);
        set_sda(1'b0);
        set_scl(1'b0); set_sda(1'b1); set_scl(1'b1); set_sda(1'b0);
        chk("R7 rep before reset", 3'b111);
        rst = 1'b1;
        #STEP;
        chk("R8 async clear", 3'b000);
        set_sda(1'b1); set_sda(1'b0);
        chk("R8 held in reset", 3'b000);
        rst = 1'b0;
        #STEP;
        chk("R8 after release", 3'b000);
        set_sda(1'b1);
        chk("R4 stop on idle bus", 3'b000);
        set_sda(1'b0);
        chk("R1 start after reset", 3'b100);

        finish_run();
    end

    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog expired at %0t", $time);
        finish_run();
    end

endmodule